// File: doc/BRIEF.md
# Parallel Prefix Magnitude Comparator

This block compares two unsigned operands of a parameterised width and reports greater-than, less-than, equal, greater-or-equal and less-or-equal together. Each bit position gets its own greater, less and equality terms. A position's greater or less term counts only when every more significant position is equal, and that check is a single wide AND rather than a ripple chain. The final greater and less flags are each one wide OR over all positions. The equal flag is a wide AND of the per-bit equality terms. Greater-or-equal and less-or-equal are inversions of less-than and greater-than.

Operands arrive on a valid/ready stream, and results leave on a second valid/ready stream through a single output register. A pair is accepted on any clock edge where `in_valid` and `in_ready` are both high. Its five flags appear with `out_valid` one cycle later. When `out_valid` is high and `out_ready` is low, the output holds and `in_ready` drops, so back-pressure passes straight to the source.

Setting the width parameter lets one block serve as a general integer comparator, as a 15-bit or 31-bit comparator for floating-point magnitudes with the sign removed, or as a 5-bit or 8-bit exponent comparator.

Top module: `prefix_mag_cmp`

## Requirements
- R1: For an accepted pair, `gt` is high exactly when `a` is greater than `b`, with both read as unsigned.
- R2: For an accepted pair, `lt` is high exactly when `a` is less than `b`, with both read as unsigned.
- R3: For an accepted pair, `eq` is high exactly when every bit of `a` equals the matching bit of `b`.
- R4: `ge` is always the inverse of `lt` for the same result.
- R5: `le` is always the inverse of `gt` for the same result.
- R6: Whenever `out_valid` is high, exactly one of `gt`, `lt` and `eq` is high.
- R7: The most significant differing bit (bit W-1 downward) alone decides the order. For example, with W=8, a=8'h80 and b=8'h7F give `gt`.
- R8: A synchronous active-high `rst` clears `out_valid` and all five flags to 0 at the next clock edge.
- R9: A pair accepted at a clock edge (`in_valid` and `in_ready` high) sets `out_valid` and shows its flags after that same edge, which is a latency of one cycle.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and all flags keep their values.
- R11: Requirements R1 to R6 hold for W = 5, 8 and 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| out_valid | output | 1 | Result flags are valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| gt | output | 1 | a > b |
| lt | output | 1 | a < b |
| eq | output | 1 | a == b |
| ge | output | 1 | a >= b |
| le | output | 1 | a <= b |

## Verification
The assertions assume that `a`, `b` and `in_valid` have defined values at every clock edge outside reset. They also assume that `in_valid` is low while reset is applied, so the previous-cycle operand comparison only ever refers to a pair that was actually accepted. The stimulus changes inputs only at falling edges, keeps `in_valid` low during reset, and never drives unknown values. Operands come from exhaustive sweeps at widths 5 and 8 and from seeded random values at width 31.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic ge;
    logic le;
  } rel_t;

  localparam int unsigned REL_W = $bits(rel_t);
endpackage

// File: rtl/cmp_bit_terms.sv
// Per-position relation terms. Index 0 of every vector is the most
// significant position of the operands.
module cmp_bit_terms #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pos_a,
  input  logic [W-1:0] pos_b,
  output logic [W-1:0] bit_gt,
  output logic [W-1:0] bit_lt,
  output logic [W-1:0] bit_eq
);
  logic [W-1:0] both_one;
  logic [W-1:0] both_zero;

  for (genvar p = 0; p < W; p++) begin : g_pos
    assign bit_gt[p]    = pos_a[p] & ~pos_b[p];
    assign bit_lt[p]    = ~pos_a[p] & pos_b[p];
    assign both_one[p]  = pos_a[p] & pos_b[p];
    assign both_zero[p] = ~(pos_a[p] | pos_b[p]);
    assign bit_eq[p]    = both_one[p] | both_zero[p];
  end
endmodule

// File: rtl/cmp_prefix_eq.sv
// Flat prefix equality: position p is enabled when all positions above it
// (indices 0..p-1) are equal. Each term is one wide AND, with no chaining.
module cmp_prefix_eq #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bit_eq,
  output logic [W-1:0] pre_eq
);
  assign pre_eq[0] = 1'b1;

  for (genvar p = 1; p < W; p++) begin : g_pre
    assign pre_eq[p] = &bit_eq[p-1:0];
  end
endmodule

// File: rtl/cmp_resolve.sv
// Gates each position's decision by its prefix equality, then reduces the
// results with wide OR and AND gates.
module cmp_resolve
  import cmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bit_gt,
  input  logic [W-1:0] bit_lt,
  input  logic [W-1:0] bit_eq,
  input  logic [W-1:0] pre_eq,
  output rel_t         rel
);
  logic [W-1:0] casc_gt;
  logic [W-1:0] casc_lt;
  logic         not_lt;
  logic         not_gt;

  assign casc_gt[0] = bit_gt[0];
  assign casc_lt[0] = bit_lt[0];

  for (genvar p = 1; p < W; p++) begin : g_casc
    assign casc_gt[p] = pre_eq[p] & bit_gt[p];
    assign casc_lt[p] = pre_eq[p] & bit_lt[p];
  end

  assign not_lt = ~(|casc_lt);
  assign not_gt = ~(|casc_gt);

  always_comb begin
    rel.gt = |casc_gt;
    rel.lt = |casc_lt;
    rel.eq = &bit_eq;
    rel.ge = not_lt;
    rel.le = not_gt;
  end
endmodule

// File: rtl/prefix_mag_cmp.sv
module prefix_mag_cmp
  import cmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         gt,
  output logic         lt,
  output logic         eq,
  output logic         ge,
  output logic         le
);
  logic [W-1:0] pos_a;
  logic [W-1:0] pos_b;
  logic [W-1:0] bit_gt;
  logic [W-1:0] bit_lt;
  logic [W-1:0] bit_eq;
  logic [W-1:0] pre_eq;
  rel_t         rel_c;
  rel_t         rel_q;
  logic         vld_q;

  // Position p maps to operand bit W-1-p, so position 0 is the MSB.
  for (genvar p = 0; p < W; p++) begin : g_map
    assign pos_a[p] = a[W-1-p];
    assign pos_b[p] = b[W-1-p];
  end

  cmp_bit_terms #(.W(W)) u_terms (
    .pos_a  (pos_a),
    .pos_b  (pos_b),
    .bit_gt (bit_gt),
    .bit_lt (bit_lt),
    .bit_eq (bit_eq)
  );

  cmp_prefix_eq #(.W(W)) u_prefix (
    .bit_eq (bit_eq),
    .pre_eq (pre_eq)
  );

  cmp_resolve #(.W(W)) u_resolve (
    .bit_gt (bit_gt),
    .bit_lt (bit_lt),
    .bit_eq (bit_eq),
    .pre_eq (pre_eq),
    .rel    (rel_c)
  );

  assign in_ready = ~vld_q | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      rel_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (in_valid && in_ready) rel_q <= rel_c;
    end
  end

  assign out_valid = vld_q;
  assign gt        = rel_q.gt;
  assign lt        = rel_q.lt;
  assign eq        = rel_q.eq;
  assign ge        = rel_q.ge;
  assign le        = rel_q.le;
endmodule

// File: rtl/prefix_mag_cmp_chk.sv
module prefix_mag_cmp_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_valid,
  input logic         out_ready,
  input logic         gt,
  input logic         lt,
  input logic         eq,
  input logic         ge,
  input logic         le
);
  assert_gt_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (gt == ($past(a) > $past(b))));

  assert_lt_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (lt == ($past(a) < $past(b))));

  assert_eq_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (eq == ($past(a) == $past(b))));

  assert_ge_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ge == !lt));

  assert_le_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (le == !gt));

  assert_one_rel_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({gt, lt, eq}) == 1));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !gt && !lt && !eq && !ge && !le));

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable({gt, lt, eq, ge, le})));
endmodule

bind prefix_mag_cmp prefix_mag_cmp_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .gt        (gt),
  .lt        (lt),
  .eq        (eq),
  .ge        (ge),
  .le        (le)
);

// File: tb/prefix_mag_cmp_tb.sv
`timescale 1ns/1ps
module prefix_mag_cmp_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // 8-bit instance
  logic       v8, r8, ov8, or8;
  logic [7:0] a8, b8;
  logic       gt8, lt8, eq8, ge8, le8;
  // 5-bit instance
  logic       v5, r5, ov5, or5;
  logic [4:0] a5, b5;
  logic       gt5, lt5, eq5, ge5, le5;
  // 31-bit instance
  logic        v31, r31, ov31, or31;
  logic [30:0] a31, b31;
  logic        gt31, lt31, eq31, ge31, le31;

  prefix_mag_cmp #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .in_valid(v8), .in_ready(r8), .a(a8), .b(b8),
    .out_valid(ov8), .out_ready(or8),
    .gt(gt8), .lt(lt8), .eq(eq8), .ge(ge8), .le(le8));

  prefix_mag_cmp #(.W(5)) u_dut5 (
    .clk(clk), .rst(rst), .in_valid(v5), .in_ready(r5), .a(a5), .b(b5),
    .out_valid(ov5), .out_ready(or5),
    .gt(gt5), .lt(lt5), .eq(eq5), .ge(ge5), .le(le5));

  prefix_mag_cmp #(.W(31)) u_dut31 (
    .clk(clk), .rst(rst), .in_valid(v31), .in_ready(r31), .a(a31), .b(b31),
    .out_valid(ov31), .out_ready(or31),
    .gt(gt31), .lt(lt31), .eq(eq31), .ge(ge31), .le(le31));

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Compares the five flags with the arithmetic relation of ea and eb.
  task automatic check_rel(input string tag, input logic [31:0] ea, input logic [31:0] eb,
                           input logic ov, input logic g, input logic l,
                           input logic e, input logic ge_o, input logic le_o);
    logic [5:0] act;
    logic [5:0] exp;
    act = {ov, g, l, e, ge_o, le_o};
    exp = {1'b1, ea > eb, ea < eb, ea == eb, ea >= eb, ea <= eb};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s R1/R2/R3/R4/R5/R6 a=%0d b=%0d actual{v,gt,lt,eq,ge,le}=%b expected=%b",
               tag, ea, eb, act, exp);
    end
  endtask

  task automatic check_zero(input string tag);
    check_bit({tag, " R8 8b"},  |{ov8, gt8, lt8, eq8, ge8, le8}, 1'b0);
    check_bit({tag, " R8 5b"},  |{ov5, gt5, lt5, eq5, ge5, le5}, 1'b0);
    check_bit({tag, " R8 31b"}, |{ov31, gt31, lt31, eq31, ge31, le31}, 1'b0);
  endtask

  initial begin
    v8 = 0; v5 = 0; v31 = 0;
    or8 = 1; or5 = 1; or31 = 1;
    a8 = 0; b8 = 0; a5 = 0; b5 = 0; a31 = 0; b31 = 0;
    repeat (3) @(negedge clk);
    check_zero("reset");
    rst = 0;

    // R7 / R9: MSB-decided order, result one cycle after acceptance.
    @(negedge clk);
    a8 = 8'h80; b8 = 8'h7F; v8 = 1;
    @(negedge clk);
    check_rel("R7 R9 msb decides", 32'h80, 32'h7F, ov8, gt8, lt8, eq8, ge8, le8);
    v8 = 0;
    @(negedge clk);
    check_bit("R9 idle drops out_valid", ov8, 1'b0);

    // R11 at W=8: exhaustive sweep, one pair per cycle.
    begin
      logic [7:0] pa, pb;
      bit have;
      have = 0;
      pa = '0; pb = '0;
      for (int i = 0; i < 65536; i++) begin
        @(negedge clk);
        if (have) check_rel("R11 w8 sweep", {24'd0, pa}, {24'd0, pb}, ov8, gt8, lt8, eq8, ge8, le8);
        a8 = i[15:8]; b8 = i[7:0]; v8 = 1;
        pa = i[15:8]; pb = i[7:0]; have = 1;
      end
      @(negedge clk);
      check_rel("R11 w8 sweep", {24'd0, pa}, {24'd0, pb}, ov8, gt8, lt8, eq8, ge8, le8);
      v8 = 0;
    end

    // R10: back-pressure holds the result and blocks input.
    @(negedge clk);
    a8 = 8'd5; b8 = 8'd3; v8 = 1; or8 = 1;
    @(negedge clk);
    a8 = 8'd1; b8 = 8'd9; or8 = 0;
    #1;
    check_bit("R10 in_ready low under stall", r8, 1'b0);
    @(negedge clk);
    check_rel("R10 held result", 32'd5, 32'd3, ov8, gt8, lt8, eq8, ge8, le8);
    @(negedge clk);
    check_rel("R10 held result again", 32'd5, 32'd3, ov8, gt8, lt8, eq8, ge8, le8);
    or8 = 1;
    @(negedge clk);
    check_rel("R9 R10 after release", 32'd1, 32'd9, ov8, gt8, lt8, eq8, ge8, le8);
    v8 = 0;
    @(negedge clk);
    check_bit("R10 drained", ov8, 1'b0);

    // R11 at W=5: exhaustive.
    begin
      logic [4:0] pa, pb;
      bit have;
      have = 0;
      pa = '0; pb = '0;
      for (int i = 0; i < 1024; i++) begin
        @(negedge clk);
        if (have) check_rel("R11 w5 sweep", {27'd0, pa}, {27'd0, pb}, ov5, gt5, lt5, eq5, ge5, le5);
        a5 = i[9:5]; b5 = i[4:0]; v5 = 1;
        pa = i[9:5]; pb = i[4:0]; have = 1;
      end
      @(negedge clk);
      check_rel("R11 w5 sweep", {27'd0, pa}, {27'd0, pb}, ov5, gt5, lt5, eq5, ge5, le5);
      v5 = 0;
    end

    // R11 at W=31: random pairs, every third one forced equal or one-bit apart.
    begin
      logic [30:0] pa, pb;
      bit have;
      void'($urandom(32'd7));
      have = 0;
      pa = '0; pb = '0;
      for (int i = 0; i < 4000; i++) begin
        logic [30:0] na, nb;
        @(negedge clk);
        if (have) check_rel("R11 w31 random", {1'b0, pa}, {1'b0, pb}, ov31, gt31, lt31, eq31, ge31, le31);
        na = 31'($urandom());
        nb = 31'($urandom());
        if (i % 3 == 0) nb = na;
        if (i % 3 == 1) nb = na ^ (31'd1 << (i % 31));
        a31 = na; b31 = nb; v31 = 1;
        pa = na; pb = nb; have = 1;
      end
      @(negedge clk);
      check_rel("R11 w31 random", {1'b0, pa}, {1'b0, pb}, ov31, gt31, lt31, eq31, ge31, le31);
      v31 = 0;
    end

    // R8: reset while results are nonzero clears everything.
    @(negedge clk);
    a8 = 8'd200; b8 = 8'd1; v8 = 1;
    a31 = 31'd3; b31 = 31'd3; v31 = 1;
    @(negedge clk);
    v8 = 0; v31 = 0; rst = 1;
    @(negedge clk);
    check_zero("mid-run reset");
    rst = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule